// File: doc/BRIEF.md
# One-Shot Sync Word Detector

This block sits behind a bit demodulator and watches the recovered serial stream, one bit per strobe. It keeps a sliding window over the last sixteen bits and compares it on every strobe with a programmable sync pattern. A match raises a sticky interrupt. The search then locks out, and nothing re-arms it except a low-then-high cycle of the modem enable.

A raw capture mode is also provided. In that mode every received bit is packed into sixteen-bit words with no alignment of any kind. Each finished word raises a data-ready flag. If the previous word was never read, the new word replaces it and a sticky overrun flag is set.

An optional gate holds back raw word delivery until the sync pattern has been acquired. That acquisition is reported on its own status output. The host drives the block through simple single-cycle strobes.

Top module: `sync_word_detect`

## Requirements
- R1: The pattern register resets to 0xCB23 on `rst_n` low and again on a `reset_cmd` strobe. A `pat_wr` strobe loads `pat_wdata`, and `reset_cmd` wins if both are present.
- R2: Each accepted bit enters the window at bit 0. A match requires at least 16 bits since enable, and the window including the current bit must equal the pattern. It is evaluated on the current strobe. With `raw_mode`=0, a match sets `sync_irq` on the next cycle, and `sync_irq` stays set until an `irq_ack` strobe.
- R3: While `modem_en` is 0, no bits are accepted. The window, the fill count, the word bit count, the lock-out, `sync_acq`, `data_rdy`, `overrun` and `rx_word` are all cleared.
- R4: After one match, no further match is reported until `modem_en` has gone low and high again.
- R5: With `raw_mode`=1 and `gate_en`=0, each group of 16 bits since enable is placed in `rx_word` with the oldest bit in bit 15, and `data_rdy` is set.
- R6: A `word_rd` strobe clears `data_rdy`. A word finishing on the same cycle keeps it set.
- R7: A word that finishes while `data_rdy` is set and `word_rd` is absent overwrites `rx_word` and sets the sticky `overrun` flag.
- R8: With `raw_mode`=1 and `gate_en`=1, no word is delivered before a match. A match sets `sync_acq`. The first word is made of the 16 bits that follow the matching bit.
- R9: With `raw_mode`=1, a match reports only through `sync_acq` and never sets `sync_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_cmd | input | 1 | Strobe restoring the preset pattern |
| pat_wr | input | 1 | Pattern write strobe |
| pat_wdata | input | 16 | Pattern write data |
| modem_en | input | 1 | Modem enable; low clears and re-arms |
| raw_mode | input | 1 | 1 = raw word capture, 0 = formatted search |
| gate_en | input | 1 | Raw mode: wait for sync before delivering words |
| bit_vld | input | 1 | Received bit strobe |
| bit_in | input | 1 | Received bit value |
| word_rd | input | 1 | Host read strobe of `rx_word` |
| irq_ack | input | 1 | Clears `sync_irq` |
| sync_irq | output | 1 | Sticky sync-found interrupt |
| sync_acq | output | 1 | Raw mode sync acquired |
| rx_word | output | 16 | Last completed raw word |
| data_rdy | output | 1 | Unread word present |
| overrun | output | 1 | Sticky word-lost flag |

## Verification
The hardest state to reach from the ports is a window that holds stale bits left over from before an enable toggle. Such bits would complete the pattern with fresh ones if the clear were missing. The stimulus sends ten pattern bits, drops and restores enable, and then sends the last six, so any stale bit would produce a false match.

The lock-out is exercised by acknowledging the first interrupt and then streaming the pattern a second time. The bench also sweeps several patterns, including all-zeros and all-ones, through pseudo-random streams that it checks bit by bit against a model of its own.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int SWD_W = 16;
    localparam logic [SWD_W-1:0] SWD_PRESET = 16'hCB23;

    typedef struct packed {
        logic locked;
        logic irq;
        logic acq;
    } swd_ctrl_t;
endpackage

// File: rtl/swd_pattern_reg.sv
module swd_pattern_reg #(
    parameter int W = swd_pkg::SWD_W,
    parameter logic [W-1:0] PRESET = swd_pkg::SWD_PRESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_cmd,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pattern
);
    logic [W-1:0] pat_d, pat_q;

    always_comb begin
        pat_d = pat_q;
        if (preset_cmd) begin
            pat_d = PRESET;
        end else if (wr) begin
            pat_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= PRESET;
        end else begin
            pat_q <= pat_d;
        end
    end

    assign pattern = pat_q;
endmodule

// File: rtl/swd_window.sv
module swd_window #(
    parameter int W = swd_pkg::SWD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] win_nxt,
    output logic         full_nxt
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  win;
        logic [CW-1:0] fill;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        win_nxt  = {st_q.win[W-2:0], bit_in};
        full_nxt = shift && (st_q.fill >= CW'(W - 1));
        if (clr) begin
            st_d = '0;
        end else if (shift) begin
            st_d.win = win_nxt;
            if (st_q.fill != CW'(W)) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swd_capture.sv
module swd_capture #(
    parameter int W = swd_pkg::SWD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         accept,
    input  logic [W-1:0] win_nxt,
    input  logic         rd,
    output logic [W-1:0] word,
    output logic         rdy,
    output logic         ovr
);
    localparam int BW = $clog2(W);

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic [W-1:0]  word;
        logic          rdy;
        logic          ovr;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    done;

    always_comb begin
        st_d = st_q;
        done = accept && (st_q.cnt == BW'(W - 1));
        if (clr) begin
            st_d = '0;
        end else begin
            if (rd) begin
                st_d.rdy = 1'b0;
            end
            if (accept) begin
                st_d.cnt = done ? '0 : st_q.cnt + 1'b1;
            end
            if (done) begin
                st_d.word = win_nxt;
                st_d.rdy  = 1'b1;
                if (st_q.rdy && !rd) begin
                    st_d.ovr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign rdy  = st_q.rdy;
    assign ovr  = st_q.ovr;
endmodule

// File: rtl/sync_word_detect.sv
module sync_word_detect
    import swd_pkg::*;
#(
    parameter int W = SWD_W,
    parameter logic [W-1:0] PRESET = SWD_PRESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reset_cmd,
    input  logic         pat_wr,
    input  logic [W-1:0] pat_wdata,
    input  logic         modem_en,
    input  logic         raw_mode,
    input  logic         gate_en,
    input  logic         bit_vld,
    input  logic         bit_in,
    input  logic         word_rd,
    input  logic         irq_ack,
    output logic         sync_irq,
    output logic         sync_acq,
    output logic [W-1:0] rx_word,
    output logic         data_rdy,
    output logic         overrun
);
    logic [W-1:0] pattern;
    logic [W-1:0] win_nxt;
    logic         full_nxt;
    logic         shift;
    logic         clr;
    logic         hit;
    logic         accept;
    swd_ctrl_t    ctl_d, ctl_q;

    assign clr    = !modem_en;
    assign shift  = modem_en && bit_vld;
    assign hit    = full_nxt && !ctl_q.locked && (win_nxt == pattern);
    assign accept = shift && raw_mode && (!gate_en || ctl_q.acq);

    swd_pattern_reg #(.W(W), .PRESET(PRESET)) pat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_cmd (reset_cmd),
        .wr         (pat_wr),
        .wdata      (pat_wdata),
        .pattern    (pattern)
    );

    swd_window #(.W(W)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift    (shift),
        .bit_in   (bit_in),
        .win_nxt  (win_nxt),
        .full_nxt (full_nxt)
    );

    swd_capture #(.W(W)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .accept  (accept),
        .win_nxt (win_nxt),
        .rd      (word_rd),
        .word    (rx_word),
        .rdy     (data_rdy),
        .ovr     (overrun)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (irq_ack) begin
            ctl_d.irq = 1'b0;
        end
        if (clr) begin
            ctl_d.locked = 1'b0;
            ctl_d.acq    = 1'b0;
        end else if (hit) begin
            ctl_d.locked = 1'b1;
            if (raw_mode) begin
                ctl_d.acq = 1'b1;
            end else begin
                ctl_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sync_irq = ctl_q.irq;
    assign sync_acq = ctl_q.acq;
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int W = 16,
    parameter logic [W-1:0] PRESET = 16'hCB23
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reset_cmd,
    input logic         modem_en,
    input logic         raw_mode,
    input logic         bit_vld,
    input logic         word_rd,
    input logic         irq_ack,
    input logic         sync_irq,
    input logic         sync_acq,
    input logic         data_rdy,
    input logic         overrun,
    input logic [W-1:0] pattern
);
    p_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> pattern == PRESET);

    p_irq_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_irq && !irq_ack) |=> sync_irq);

    p_disable_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_en |=> (!data_rdy && !overrun && !sync_acq));

    p_rdy_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy) |-> ($past(raw_mode) && $past(bit_vld) && $past(modem_en)));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && word_rd && !bit_vld) |=> !data_rdy);

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && modem_en) |=> overrun);

    p_irq_formatted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_irq) |-> (!$past(raw_mode) && $past(bit_vld) && $past(modem_en)));
endmodule

bind sync_word_detect swd_checker #(.W(W), .PRESET(PRESET)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_cmd (reset_cmd),
    .modem_en  (modem_en),
    .raw_mode  (raw_mode),
    .bit_vld   (bit_vld),
    .word_rd   (word_rd),
    .irq_ack   (irq_ack),
    .sync_irq  (sync_irq),
    .sync_acq  (sync_acq),
    .data_rdy  (data_rdy),
    .overrun   (overrun),
    .pattern   (pattern)
);

// File: tb/sync_word_detect_tb_top.sv
`timescale 1ns/1ps
module sync_word_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_cmd = 1'b0, pat_wr = 1'b0;
    logic [15:0] pat_wdata = '0;
    logic        modem_en = 1'b0, raw_mode = 1'b0, gate_en = 1'b0;
    logic        bit_vld = 1'b0, bit_in = 1'b0, word_rd = 1'b0, irq_ack = 1'b0;
    logic        sync_irq, sync_acq, data_rdy, overrun;
    logic [15:0] rx_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] m_win;
    int          m_fill;
    bit          m_lock;
    logic [15:0] m_pat;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    sync_word_detect dut_i (
        .clk(clk), .rst_n(rst_n), .reset_cmd(reset_cmd), .pat_wr(pat_wr),
        .pat_wdata(pat_wdata), .modem_en(modem_en), .raw_mode(raw_mode),
        .gate_en(gate_en), .bit_vld(bit_vld), .bit_in(bit_in),
        .word_rd(word_rd), .irq_ack(irq_ack), .sync_irq(sync_irq),
        .sync_acq(sync_acq), .rx_word(rx_word), .data_rdy(data_rdy),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit lfsr_bit();
        bit b;
        b = lfsr[15];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return b;
    endfunction

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input bit rd);
        @(negedge clk);
        bit_vld = 1'b1; bit_in = b; word_rd = rd;
        @(negedge clk);
        bit_vld = 1'b0; word_rd = 1'b0;
    endtask

    task automatic toggle_en();
        @(negedge clk); modem_en = 1'b0;
        @(negedge clk); modem_en = 1'b1;
        m_win = '0; m_fill = 0; m_lock = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic write_pat(input logic [15:0] p);
        @(negedge clk); pat_wr = 1'b1; pat_wdata = p;
        @(negedge clk); pat_wr = 1'b0;
        m_pat = p;
    endtask

    // model-driven formatted-mode bit with check of sync_irq
    task automatic model_bit(input bit b);
        bit exp_hit;
        m_win = {m_win[14:0], b};
        if (m_fill < 16) m_fill++;
        exp_hit = (m_fill == 16) && !m_lock && (m_win == m_pat);
        send_bit(b, 1'b0);
        if (m_lock)
            chk(sync_irq == 1'b0, "R4 lockout", {15'd0, sync_irq}, 16'd0);
        else
            chk(sync_irq == exp_hit, "R2 match", {15'd0, sync_irq}, {15'd0, exp_hit});
        if (exp_hit) begin
            m_lock = 1'b1;
            ack();
            chk(sync_irq == 1'b0, "R2 ack clears", {15'd0, sync_irq}, 16'd0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] p;
        logic [15:0] w;
        m_pat = 16'hCB23; m_win = '0; m_fill = 0; m_lock = 1'b0;
        repeat (3) idle();
        chk({sync_irq, sync_acq, data_rdy, overrun} == 4'b0, "R3 reset flags",
            {12'd0, sync_irq, sync_acq, data_rdy, overrun}, 16'd0);
        chk(rx_word == 16'd0, "R3 reset word", rx_word, 16'd0);
        rst_n = 1'b1;
        idle();

        // R1 preset after reset, then sweep of patterns
        for (int pi = 0; pi < 10; pi++) begin
            if (pi == 0) begin
                p = 16'hCB23;
            end else if (pi == 1) begin
                p = 16'h0000;
            end else if (pi == 2) begin
                p = 16'hFFFF;
            end else begin
                p = 16'(pi * 16'h3B1D) ^ 16'h9C47;
            end
            if (pi != 0) write_pat(p);
            toggle_en();
            for (int k = 0; k < 20; k++) model_bit(lfsr_bit());
            for (int k = 15; k >= 0; k--) model_bit(p[k]);
            chk(m_lock, "R2 pattern found", {15'd0, m_lock}, 16'd1);
            for (int k = 0; k < 8; k++) model_bit(lfsr_bit());
            for (int k = 15; k >= 0; k--) model_bit(p[k]);
        end

        // R1 reset command restores preset
        write_pat(16'h1234);
        @(negedge clk); reset_cmd = 1'b1; pat_wr = 1'b1; pat_wdata = 16'h4321;
        @(negedge clk); reset_cmd = 1'b0; pat_wr = 1'b0;
        m_pat = 16'hCB23;
        toggle_en();
        for (int k = 15; k >= 0; k--) send_bit(m_pat[k], 1'b0);
        chk(sync_irq == 1'b1, "R1 preset restored", {15'd0, sync_irq}, 16'd1);
        ack();

        // R3 stale window must not complete a match
        toggle_en();
        for (int k = 15; k >= 6; k--) send_bit(m_pat[k], 1'b0);
        toggle_en();
        for (int k = 5; k >= 0; k--) send_bit(m_pat[k], 1'b0);
        chk(sync_irq == 1'b0, "R3 window cleared", {15'd0, sync_irq}, 16'd0);
        for (int k = 15; k >= 0; k--) send_bit(m_pat[k], 1'b0);
        chk(sync_irq == 1'b1, "R3 rearmed match", {15'd0, sync_irq}, 16'd1);
        ack();

        // R5 R6 R9 raw ungated
        raw_mode = 1'b1; gate_en = 1'b0;
        toggle_en();
        for (int wd = 0; wd < 3; wd++) begin
            w = '0;
            for (int k = 0; k < 16; k++) begin
                bit b;
                b = lfsr_bit();
                w = {w[14:0], b};
                send_bit(b, 1'b0);
                if (k == 7) chk(data_rdy == 1'b0, "R5 no early rdy", {15'd0, data_rdy}, 16'd0);
            end
            chk(data_rdy == 1'b1, "R5 rdy", {15'd0, data_rdy}, 16'd1);
            chk(rx_word == w, "R5 word", rx_word, w);
            @(negedge clk); word_rd = 1'b1;
            @(negedge clk); word_rd = 1'b0;
            chk(data_rdy == 1'b0, "R6 read clears", {15'd0, data_rdy}, 16'd0);
        end
        for (int k = 15; k >= 0; k--) send_bit(m_pat[k], 1'b0);
        chk(sync_irq == 1'b0, "R9 no irq in raw", {15'd0, sync_irq}, 16'd0);
        chk(sync_acq == 1'b1, "R9 acq in raw", {15'd0, sync_acq}, 16'd1);
        chk(overrun == 1'b0, "R7 no overrun", {15'd0, overrun}, 16'd0);

        // R7 overrun, then R6 read coinciding with completion
        toggle_en();
        for (int k = 0; k < 16; k++) send_bit(1'b1, 1'b0);
        w = 16'h5A3C;
        for (int k = 15; k >= 0; k--) send_bit(w[k], 1'b0);
        chk(overrun == 1'b1, "R7 overrun set", {15'd0, overrun}, 16'd1);
        chk(rx_word == w, "R7 overwrite", rx_word, w);
        w = 16'h0F0F;
        for (int k = 15; k >= 1; k--) send_bit(w[k], 1'b0);
        send_bit(w[0], 1'b1);
        chk(data_rdy == 1'b1, "R6 completion wins", {15'd0, data_rdy}, 16'd1);
        chk(overrun == 1'b1, "R7 sticky", {15'd0, overrun}, 16'd1);
        @(negedge clk); modem_en = 1'b0;
        @(negedge clk);
        chk({data_rdy, overrun, sync_acq} == 3'b0, "R3 disable clears",
            {13'd0, data_rdy, overrun, sync_acq}, 16'd0);
        chk(rx_word == 16'd0, "R3 word cleared", rx_word, 16'd0);

        // R8 gated raw
        gate_en = 1'b1;
        write_pat(16'hA5C3);
        toggle_en();
        for (int k = 0; k < 20; k++) send_bit(1'b0, 1'b0);
        chk(data_rdy == 1'b0, "R8 gated no word", {15'd0, data_rdy}, 16'd0);
        chk(sync_acq == 1'b0, "R8 no acq yet", {15'd0, sync_acq}, 16'd0);
        for (int k = 15; k >= 0; k--) send_bit(m_pat[k], 1'b0);
        chk(sync_acq == 1'b1, "R8 acq", {15'd0, sync_acq}, 16'd1);
        chk(data_rdy == 1'b0, "R8 match bit not a word", {15'd0, data_rdy}, 16'd0);
        w = 16'h3C96;
        for (int k = 15; k >= 0; k--) send_bit(w[k], 1'b0);
        chk(data_rdy == 1'b1, "R8 first word rdy", {15'd0, data_rdy}, 16'd1);
        chk(rx_word == w, "R8 first word", rx_word, w);
        chk(sync_irq == 1'b0, "R9 gated no irq", {15'd0, sync_irq}, 16'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule